// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Debounce

This block scans a keyboard of six rows by eight columns and reports one key per press. While idle it energizes every row together and watches the column sense lines. A nonzero column value starts a debounce interval; if the columns seen before and after that interval have no bit in common the press is thrown away, otherwise the rows are energized one at a time, from the top row downwards, to find the pressed key.

The keycode is built by counting, not decoding. The count goes up by eight for every row found empty. In the row that holds the key, the captured column value is shifted right one place per cycle and the count goes up by one per shift until the next shift would leave zero. After that the block drives all rows again and waits for a debounced release. Only then does it present the code with a one-cycle valid pulse. The column lines are asynchronous and pass through a two-flop synchronizer. The debounce length is a parameter in clock cycles, which is the wanted time multiplied by the clock frequency.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset, row_drive is all ones, key_valid is 0 and key_code is 0.
- R2: row_drive is either all ones (idle, debounce, release wait) or one-hot (row scan). Row index r, counted from the top, is driven on row_drive bit ROWS-1-r.
- R3: A press that is gone when the debounce sample is taken produces no key_valid.
- R4: The key at row r and column c (column c read on col_sense bit c) is reported as key_code = 8*r + c, in the range 0 to 47.
- R5: key_valid is never raised while the key is still held.
- R6: Each accepted press gives exactly one key_valid pulse, one cycle wide.
- R7: With several keys down, the topmost row holding a key wins, and within that row the highest column wins.
- R8: If the columns seen at detection and at the debounce sample share no bit, that detection is dropped; a key still held then gets a fresh detection and is reported once with its own code.
- R9: key_valid follows the release within 2*(DEBOUNCE_CYCLES+2)+8 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_sense | input | COLS | Column sense lines, active high, asynchronous |
| row_drive | output | ROWS | Row drive lines, active high |
| key_valid | output | 1 | One-cycle pulse when key_code holds a released key |
| key_code | output | 6 | Keycode, row*8 + column |

## Verification
A column change reaches the synchronized value two edges after it shows on the pins, and each row of the scan waits those two edges before it is judged. A held key is therefore reported no sooner than the debounce interval after release, and no later than the R9 bound. The bench samples at the falling edge, keeps a monitor that counts every pulse and flags any pulse seen while a key is held, and after each release it counts cycles to the pulse against the R9 limit. It then idles for several debounce intervals to show that no second pulse follows.

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner #(
  parameter int ROWS            = 6,
  parameter int COLS            = 8,
  parameter int DEBOUNCE_CYCLES = 250000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [COLS-1:0]                   col_sense,
  output logic [ROWS-1:0]                   row_drive,
  output logic                              key_valid,
  output logic [$clog2(ROWS*COLS)-1:0]      key_code
);
  localparam int CODE_W = $clog2(ROWS*COLS);
  localparam int SETTLE = 2;
  localparam int CW     = $clog2(DEBOUNCE_CYCLES + SETTLE + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DBP, S_ROW, S_COL, S_REL, S_DBR, S_EMIT
  } st_t;

  st_t              state;
  logic [COLS-1:0]  sync1, col_s2, first, colv;
  logic [ROWS-1:0]  row_sel;
  logic [CODE_W-1:0] code;
  logic [CW-1:0]    cnt;

  wire [COLS-1:0] nxt      = colv >> 1;
  wire            db_end   = (cnt == CW'(DEBOUNCE_CYCLES - 1));
  wire            set_end  = (cnt == CW'(SETTLE));
  wire            agree    = ((col_s2 & first) != '0);

  assign row_drive = (state == S_ROW) ? row_sel : '1;
  assign key_valid = (state == S_EMIT);
  assign key_code  = code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      col_s2 <= '0;
    end else begin
      sync1  <= col_sense;
      col_s2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      first   <= '0;
      colv    <= '0;
      row_sel <= '0;
      code    <= '0;
      cnt     <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (col_s2 != '0) begin
            first <= col_s2;
            cnt   <= '0;
            state <= S_DBP;
          end
        S_DBP:
          if (db_end) begin
            cnt <= '0;
            if (agree) begin
              row_sel <= {1'b1, {(ROWS-1){1'b0}}};
              code    <= '0;
              state   <= S_ROW;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_ROW:
          if (set_end) begin
            cnt <= '0;
            if (col_s2 != '0) begin
              colv  <= col_s2;
              state <= S_COL;
            end else begin
              code    <= code + CODE_W'(COLS);
              row_sel <= row_sel >> 1;
              if (row_sel[0]) state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_COL:
          if (nxt == '0) begin
            cnt   <= '0;
            state <= S_REL;
          end else begin
            code <= code + 1'b1;
            colv <= nxt;
          end
        S_REL:
          if (set_end) begin
            cnt   <= '0;
            first <= col_s2;
            state <= S_DBR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_DBR:
          if (db_end) begin
            cnt   <= '0;
            state <= agree ? S_REL : S_EMIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_EMIT:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_rows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_drive == '1) || $onehot(row_drive));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> ({1'b0, key_code} < (CODE_W+1)'(ROWS*COLS)));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && col_sense == '0 && sync1 == '0 && col_s2 == '0)
      |=> (state == S_IDLE && !key_valid));

  p_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> ($past(state) == S_DBR && row_drive == '1));
endmodule

// File: tb/test_key_matrix_scanner.sv
module test_key_matrix_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 6;
  localparam int COLS = 8;
  localparam int DB   = 20;
  localparam int LIM  = 2*(DB+2)+8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [COLS-1:0] col_sense;
  logic [ROWS-1:0] row_drive;
  logic            key_valid;
  logic [5:0]      key_code;

  logic [COLS-1:0] keys [ROWS];
  int total = 0, bad = 0;
  int vcount = 0, early = 0, rowbad = 0;
  logic [5:0] vcode = '0;
  logic holding = 0;

  key_matrix_scanner #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE_CYCLES(DB)) i_key_matrix_scanner (
    .clk(clk), .rst_n(rst_n), .col_sense(col_sense),
    .row_drive(row_drive), .key_valid(key_valid), .key_code(key_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    col_sense = '0;
    for (int r = 0; r < ROWS; r++)
      if (row_drive[ROWS-1-r]) col_sense = col_sense | keys[r];
  end

  always @(negedge clk) begin
    if (key_valid) begin
      vcount <= vcount + 1;
      vcode  <= key_code;
      if (holding) early <= early + 1;
    end
    if (rst_n && !(row_drive == '1 || $onehot(row_drive))) rowbad <= rowbad + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_keys();
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
  endtask

  task automatic settle_quiet();
    repeat (4*DB) @(negedge clk);
    vcount = 0; early = 0;
  endtask

  // press a set of keys already placed in keys[], hold, release, expect code
  task automatic press_release(input int exp_code, input string tag);
    int lat;
    holding = 1;
    repeat (120) @(negedge clk);
    holding = 0;
    chk(early == 0, "R5 no pulse while held", early, 0);
    clear_keys();
    lat = 0;
    while (vcount == 0 && lat < 4*LIM) begin
      @(negedge clk);
      lat++;
    end
    chk(lat <= LIM, "R9 release latency", lat, LIM);
    chk(vcode == 6'(exp_code), tag, int'(vcode), exp_code);
    repeat (4*DB) @(negedge clk);
    chk(vcount == 1, "R6 one pulse per press", vcount, 1);
    vcount = 0;
  endtask

  task automatic t_reset();
    chk(row_drive == '1, "R1 rows after reset", int'(row_drive), 63);
    chk(key_valid == 0, "R1 valid after reset", int'(key_valid), 0);
    chk(key_code == 0, "R1 code after reset", int'(key_code), 0);
  endtask

  task automatic t_idle_rows();
    repeat (10) @(negedge clk);
    chk(row_drive == '1, "R2 idle drives all rows", int'(row_drive), 63);
  endtask

  task automatic t_single(input int r, input int c);
    clear_keys();
    keys[r][c] = 1'b1;
    press_release(8*r + c, "R4 keycode");
  endtask

  task automatic t_multi_same_row();
    clear_keys();
    keys[3][2] = 1'b1;
    keys[3][6] = 1'b1;
    press_release(30, "R7 highest column wins");
  endtask

  task automatic t_multi_rows();
    clear_keys();
    keys[1][4] = 1'b1;
    keys[4][0] = 1'b1;
    press_release(12, "R7 top row wins");
  endtask

  task automatic t_short_press();
    clear_keys();
    keys[2][3] = 1'b1;
    repeat (3) @(negedge clk);
    clear_keys();
    repeat (4*DB) @(negedge clk);
    chk(vcount == 0, "R3 short press ignored", vcount, 0);
    vcount = 0;
  endtask

  task automatic t_moved_key();
    clear_keys();
    keys[0][1] = 1'b1;
    repeat (3 + DB/2) @(negedge clk);
    keys[0][1] = 1'b0;
    keys[5][6] = 1'b1;
    press_release(46, "R8 changed key reported once");
  endtask

  initial begin
    clear_keys();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_idle_rows();
    t_single(0, 0);
    t_single(1, 1);
    t_single(5, 7);
    t_single(2, 5);
    t_multi_same_row();
    t_multi_rows();
    t_short_press();
    t_moved_key();
    settle_quiet();
    chk(rowbad == 0, "R2 rows all-on or one-hot", rowbad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule